// File: doc/BRIEF.md
# Output Driver Impedance Calibration Scheduler

This block holds the strength code that sets an output driver's impedance. An analog comparator outside the block looks at the present code and asks for a stronger or a weaker setting. The block acts on that request only at fixed evaluation points, and it moves the code by at most one step each time. A larger code means a stronger driver and so a lower output impedance. An evaluation can land while the pins are driving a read. In that case the new code is held back and reaches the driver only in a cycle where the outputs float, so the driver strength never changes during a driven transfer.

The block also counts cycles that carry no read. Once enough of them have passed since reset, it raises a flag to say the driver has had time to settle. A static strap bypasses tracking altogether and pins the code at its strongest setting, which is the lowest impedance.

Top module: `zq_cal_sched`

## Requirements
- R1: An evaluation takes place in the 32nd clock cycle after reset is released, then in every 32nd cycle after that. The code cannot change at any other edge, except for an applied pending step (R4) and the strap (R6).
- R2: At an evaluation, `cmp_up`=1 with `cmp_dn`=0 gives a target one above the applied code, and `cmp_dn`=1 with `cmp_up`=0 gives one below it. Both inputs high, or both low, means equal: the target becomes the applied code itself, which discards any pending step.
- R3: The code saturates rather than wrapping. It stays at 63 (all ones, CODE_W=6) when asked to go up and at 0 when asked to go down.
- R4: `code` takes on the target only at an edge where `out_hiz`=1. An evaluation in such a cycle reaches `code` at that same edge. A step evaluated while `out_hiz`=0 is held and applied at the first later edge with `out_hiz`=1. While `out_hiz`=0 and the strap is low, `code` does not change.
- R5: Each evaluation computes its target from the applied code, not from an older pending target. The code therefore never moves more than one step at a time, however many evaluations pass while the outputs are driven.
- R6: While `force_min_z`=1, `code` becomes 63 at the next edge whatever the value of `out_hiz`, and the compare inputs are ignored. Once the strap is released, tracking resumes from 63.
- R7: `calibrated` rises after the 1,024th edge that samples `out_hiz`=1 since reset. Edges with `out_hiz`=0 (read cycles) do not count. Once high, the flag stays high until reset.
- R8: After reset, `code` is 32 and `calibrated` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_up | input | 1 | Comparator asks for a stronger driver |
| cmp_dn | input | 1 | Comparator asks for a weaker driver |
| out_hiz | input | 1 | Outputs are high impedance this cycle (a non-read cycle) |
| force_min_z | input | 1 | Strap that forces the strongest code |
| code | output | 6 | Strength code applied to the driver |
| calibrated | output | 1 | The power-up count of non-read cycles is complete |

## Verification
Two events can fall in the same cycle: an evaluation, and the high-impedance window that lets a code through. Which edge the step reaches `code` on depends on whether they coincide. The bench provokes both cases. Directed runs hold `out_hiz` high straight across evaluation points, and others hold it low over one or two evaluations before opening a single high-impedance cycle. Random traffic then makes the two meet at arbitrary offsets. Every cycle, `code` is compared against a bench model of R1 to R6, so a step that arrives one edge early or late, or that doubles up, shows as a miscompare.

// File: rtl/zqc_pkg.sv
package zqc_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

    function automatic step_dir_e decode_dir(input logic up, input logic dn);
        if (up && !dn) begin
            return DIR_UP;
        end else if (dn && !up) begin
            return DIR_DOWN;
        end
        return DIR_HOLD;
    endfunction

endpackage

// File: rtl/zqc_eval_timer.sv
module zqc_eval_timer #(
    parameter int EVAL_PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_o
);
    localparam int CW = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(EVAL_PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign eval_o = (s_q.cnt == LAST);

    // R1: evaluation points are never back to back
    p_eval_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eval_o |=> !eval_o);

endmodule

// File: rtl/zqc_ready_counter.sv
module zqc_ready_counter #(
    parameter int READY_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hiz_i,
    output logic ready_o
);
    localparam int RW = $clog2(READY_CYCLES + 1);
    localparam logic [RW-1:0] FULL = RW'(READY_CYCLES);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } rdy_t;

    rdy_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hiz_i && (s_q.cnt != FULL)) begin
            s_d.cnt = s_q.cnt + RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = (s_q.cnt == FULL);

    // R7: flag is sticky once raised
    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R7: read cycles leave the count untouched
    p_read_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz_i |=> $stable(s_q.cnt));

endmodule

// File: rtl/zqc_step_unit.sv
module zqc_step_unit
    import zqc_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int RESET_CODE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic              hiz_i,
    input  logic              force_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

    typedef struct packed {
        logic [CODE_W-1:0] applied;
        logic [CODE_W-1:0] target;
    } step_t;

    step_t     s_d, s_q;
    step_dir_e dir;
    logic [CODE_W-1:0] next_tgt;

    always_comb begin
        s_d      = s_q;
        dir      = decode_dir(up_i, dn_i);
        next_tgt = s_q.target;
        if (eval_i) begin
            unique case (dir)
                DIR_UP:   next_tgt = (s_q.applied == CODE_MAX) ? CODE_MAX
                                     : s_q.applied + CODE_W'(1);
                DIR_DOWN: next_tgt = (s_q.applied == CODE_MIN) ? CODE_MIN
                                     : s_q.applied - CODE_W'(1);
                default:  next_tgt = s_q.applied;
            endcase
        end
        s_d.target = next_tgt;
        if (hiz_i) begin
            s_d.applied = next_tgt;
        end
        if (force_i) begin
            s_d.target  = CODE_MAX;
            s_d.applied = CODE_MAX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.applied <= CODE_RST;
            s_q.target  <= CODE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.applied;

    // R4: driver code frozen while outputs are driven
    p_hold_driving_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hiz_i && !force_i) |=> $stable(code_o));

    // R5: at most one step per edge outside the strap
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !force_i |=> ((code_o == $past(code_o))
                   || (code_o == $past(code_o) + CODE_W'(1))
                   || (code_o == $past(code_o) - CODE_W'(1))));

    // R6: strap pins the strongest code
    p_force_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (code_o == CODE_MAX));

    // R3: no wrap from the top
    p_no_wrap_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == CODE_MAX) |=> (code_o != CODE_MIN));

endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched #(
    parameter int CODE_W       = 6,
    parameter int RESET_CODE   = 32,
    parameter int EVAL_PERIOD  = 32,
    parameter int READY_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_up,
    input  logic              cmp_dn,
    input  logic              out_hiz,
    input  logic              force_min_z,
    output logic [CODE_W-1:0] code,
    output logic              calibrated
);
    logic eval_pulse;

    zqc_eval_timer #(
        .EVAL_PERIOD (EVAL_PERIOD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval_o (eval_pulse)
    );

    zqc_step_unit #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval_i  (eval_pulse),
        .up_i    (cmp_up),
        .dn_i    (cmp_dn),
        .hiz_i   (out_hiz),
        .force_i (force_min_z),
        .code_o  (code)
    );

    zqc_ready_counter #(
        .READY_CYCLES (READY_CYCLES)
    ) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .hiz_i   (out_hiz),
        .ready_o (calibrated)
    );

    // R1: code only moves on an evaluation, a high-Z cycle or the strap
    p_move_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_pulse && !out_hiz && !force_min_z) |=> $stable(code));

endmodule

// File: tb/zq_cal_sched_bench.sv
module zq_cal_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 6;
    localparam int PERIOD     = 32;
    localparam int READY_N    = 1024;
    localparam int MAXC       = 63;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmp_up = 1'b0;
    logic         cmp_dn = 1'b0;
    logic         out_hiz = 1'b0;
    logic         force_min_z = 1'b0;
    logic [W-1:0] code;
    logic         calibrated;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state
    int m_cnt = 0;
    int m_tgt = 32;
    int m_code = 32;
    int m_ready = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    zq_cal_sched u_zq_cal_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_up      (cmp_up),
        .cmp_dn      (cmp_dn),
        .out_hiz     (out_hiz),
        .force_min_z (force_min_z),
        .code        (code),
        .calibrated  (calibrated)
    );

    function automatic int eval_target(int cur, bit up, bit dn);
        if (up && !dn) return (cur == MAXC) ? MAXC : cur + 1;
        if (dn && !up) return (cur == 0) ? 0 : cur - 1;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tgt = 32; m_code = 32; m_ready = 0;
        end else begin
            if (m_cnt == PERIOD - 1) m_tgt = eval_target(m_code, cmp_up, cmp_dn);
            m_cnt = (m_cnt == PERIOD - 1) ? 0 : m_cnt + 1;
            if (out_hiz) begin
                m_code = m_tgt;
                if (m_ready < READY_N) m_ready = m_ready + 1;
            end
            if (force_min_z) begin
                m_tgt = MAXC; m_code = MAXC;
            end
        end
    end

    task automatic check(string tag);
        vectors++;
        if (int'(code) != m_code) begin
            fails++;
            $display("FAIL %s code actual=%0d expected=%0d t=%0t", tag, code, m_code, $time);
        end
        vectors++;
        if (calibrated != (m_ready == READY_N)) begin
            fails++;
            $display("FAIL R7 calibrated actual=%0b expected=%0b t=%0t",
                     calibrated, (m_ready == READY_N), $time);
        end
    endtask

    task automatic cyc(bit up, bit dn, bit hz, bit frc, string tag);
        cmp_up = up; cmp_dn = dn; out_hiz = hz; force_min_z = frc;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C41));
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8");
        rst_n = 1'b1;
        // R7 with mixed read and non-read cycles, R4 random overlap
        for (int i = 0; i < 2400; i++) begin
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'b0, "R4");
        end
        // R1: align to an evaluation boundary, then watch two periods
        for (int i = 0; i < 64; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, "R1");
        // R3: drive to the top and hold there
        for (int i = 0; i < PERIOD * 40; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        // R3: drive to the bottom and hold there
        for (int i = 0; i < PERIOD * 70; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, "R3");
        // R5: several evaluations while driven, then one high-Z cycle
        for (int i = 0; i < PERIOD * 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R4");
        // R2: both compare inputs high means equal
        for (int i = 0; i < PERIOD * 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        // R6: strap during read cycles with a down request
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        for (int i = 0; i < PERIOD * 3; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        // mixed random with occasional strap
        for (int i = 0; i < 1500; i++) begin
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 49) == 0), "R4");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule